// File: doc/BRIEF.md
# Electrically Erasable ROM Behavioural Core

A clocked, synthesizable model of a byte-wide electrically erasable read-only memory, meant as a target for testing programmer logic. It takes an address, a data byte, active-low chip and output enables, and two encoded supply flags. The first flag gives the programming supply level: read, 12 V or 14 V. The second says whether address line 9 is driven at high voltage. From these inputs the core picks its operating mode. It then reads the array, programs one byte, erases the whole array, returns a verify read, or returns an identifier byte. Alongside the data it gives a drive-enable output that stands in for the three-state pins.

Program and erase happen on the release edge of a low pulse on chip enable. The width of that pulse is counted in clock cycles. A pulse whose width falls outside the window for its operation leaves the array untouched and sets a sticky error flag. Programming can only clear bits. Erasing is the only way to set them. The array depth is a parameter. The default keeps the array small enough to elaborate cheaply, and a full 32K array is `ADDR_W = 15`.

Top module: `eerom_core`

## Requirements
- R1: After reset every byte reads FF hex and `pulse_err` is 0.
- R2: With `vpp_lvl` = 00 (read level), `a9_hv` = 0, and `ce_n` and `oe_n` both low, `dout_en` is 1 and `dout` equals the stored byte at `addr`.
- R3: `dout_en` is 0 and `dout` is 0 whenever `oe_n` is high. They are also 0 when `ce_n` is high while `vpp_lvl` = 00.
- R4: A program pulse replaces the byte at `addr` with its old value ANDed with `din`. A program pulse is a `ce_n` low pulse that starts with `vpp_lvl` = 01 (12 V) and `oe_n` high, and whose width is from `PROG_MIN` to `PROG_MAX` sampled cycles inclusive. The address and data are captured at the first low cycle. The write takes effect at the first clock edge that samples `ce_n` high again.
- R5: An erase pulse sets every byte to FF hex. An erase pulse is a `ce_n` low pulse that starts with `vpp_lvl` = 10 (14 V), `oe_n` high, `a9_hv` = 1 and `addr` all zero, and whose width is from `ERASE_MIN` to `ERASE_MAX` cycles.
- R6: With `ce_n` high, `oe_n` low and `vpp_lvl` other than 00 (the verify modes), `dout_en` is 1 and `dout` is the stored byte at `addr`.
- R7: With `a9_hv` = 1, `vpp_lvl` = 00 and `ce_n` and `oe_n` low, `dout` is DA hex when `addr[0]` = 0 and 02 hex when `addr[0]` = 1.
- R8: A program or erase pulse outside its width window leaves the array unchanged and sets `pulse_err`. The flag stays set until reset.
- R9: A `ce_n` pulse that starts with neither the program nor the erase condition met changes no byte and does not touch `pulse_err`. This covers `vpp_lvl` = 00, and an erase attempt with a nonzero address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data to program |
| ce_n | input | 1 | Chip enable, active low; program/erase pulse |
| oe_n | input | 1 | Output enable, active low |
| vpp_lvl | input | 2 | Program supply level: 00 read, 01 12 V, 10 14 V |
| a9_hv | input | 1 | Address line 9 at high voltage |
| dout | output | DATA_W | Read, verify or identifier data (0 when not driven) |
| dout_en | output | 1 | Data output drive enable |
| pulse_err | output | 1 | Sticky: a pulse was out of its width window |

## Verification
The bench aims at the edges of both width windows: exactly `PROG_MIN` and `PROG_MAX`, one cycle short and one cycle long. An off-by-one counter would commit a short pulse, or reject a legal one and raise the error. Repeated programs of the same byte check that data is ANDed in, since a design that overwrote the byte would bring back cleared bits. Erase attempts with a nonzero address or a bad width must leave every programmed byte in place. A design that erased anyway would show FF where the model holds data. Identifier and standby reads check that the supply flags, rather than chip enable alone, steer the output path.

// File: rtl/eerom_core.sv
module eerom_core #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter logic [DATA_W-1:0] MFR_ID = 8'hDA,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h02,
  parameter int PROG_MIN  = 95,
  parameter int PROG_MAX  = 105,
  parameter int ERASE_MIN = 950,
  parameter int ERASE_MAX = 1050
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [1:0]        vpp_lvl,
  input  logic              a9_hv,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              pulse_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(ERASE_MAX + 2);
  localparam logic [CNT_W-1:0] P_LO = CNT_W'(PROG_MIN);
  localparam logic [CNT_W-1:0] P_HI = CNT_W'(PROG_MAX);
  localparam logic [CNT_W-1:0] E_LO = CNT_W'(ERASE_MIN);
  localparam logic [CNT_W-1:0] E_HI = CNT_W'(ERASE_MAX);
  localparam logic [CNT_W-1:0] C_SAT = '1;
  localparam logic [1:0] SUP_READ = 2'b00, SUP_PROG = 2'b01, SUP_ERASE = 2'b10;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_t;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              ce_q;
  logic [CNT_W-1:0]  cnt;
  op_t               op;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_din;

  wire prog_req  = (vpp_lvl == SUP_PROG) && oe_n;
  wire erase_req = (vpp_lvl == SUP_ERASE) && oe_n && a9_hv && (addr == '0);
  wire p_start   = !ce_n && ce_q;
  wire p_end     = ce_n && !ce_q;
  wire prog_ok   = (cnt >= P_LO) && (cnt <= P_HI);
  wire erase_ok  = (cnt >= E_LO) && (cnt <= E_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q      <= 1'b1;
      cnt       <= '0;
      op        <= OP_NONE;
      lat_addr  <= '0;
      lat_din   <= '0;
      pulse_err <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      ce_q <= ce_n;
      if (p_start) begin
        cnt      <= CNT_W'(1);
        op       <= erase_req ? OP_ERASE : (prog_req ? OP_PROG : OP_NONE);
        lat_addr <= addr;
        lat_din  <= din;
      end else if (!ce_n && cnt != C_SAT) begin
        cnt <= cnt + 1'b1;
      end
      if (p_end) begin
        op <= OP_NONE;
        case (op)
          OP_PROG:
            if (prog_ok) mem[lat_addr] <= mem[lat_addr] & lat_din;
            else         pulse_err <= 1'b1;
          OP_ERASE:
            if (erase_ok) for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            else          pulse_err <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  wire id_sel = a9_hv && (vpp_lvl == SUP_READ) && !ce_n;
  assign dout_en = !oe_n && (!ce_n || vpp_lvl != SUP_READ);
  assign dout    = !dout_en ? '0 : id_sel ? (addr[0] ? DEV_ID : MFR_ID) : mem[addr];
endmodule

// File: rtl/eerom_core_chk.sv
module eerom_core_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic [1:0]        vpp_lvl,
  input logic              a9_hv,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              pulse_err
);
  // R3
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_en && dout == '0));

  // R3
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && vpp_lvl == 2'b00) |-> !dout_en);

  // R7
  ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && a9_hv && vpp_lvl == 2'b00) |->
      (dout_en && dout == (addr[0] ? DATA_W'(8'h02) : DATA_W'(8'hDA))));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err |=> pulse_err);

  // R8
  err_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_err) |-> ($past(ce_n) && !$past(ce_n, 2)));
endmodule

bind eerom_core eerom_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
  .vpp_lvl(vpp_lvl), .a9_hv(a9_hv), .dout(dout), .dout_en(dout_en),
  .pulse_err(pulse_err));

// File: tb/tb_eerom_core.sv
module tb_eerom_core;
  localparam int AW = 10, DW = 8;
  localparam int PMIN = 95, PMAX = 105, EMIN = 950, EMAX = 1050;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic ce_n = 1, oe_n = 1, a9_hv = 0;
  logic [1:0] vpp_lvl = 2'b00;
  logic [DW-1:0] dout;
  logic dout_en, pulse_err;

  eerom_core #(.ADDR_W(AW), .DATA_W(DW), .PROG_MIN(PMIN), .PROG_MAX(PMAX),
               .ERASE_MIN(EMIN), .ERASE_MAX(EMAX)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_lvl(vpp_lvl), .a9_hv(a9_hv), .dout(dout), .dout_en(dout_en),
    .pulse_err(pulse_err));

  always #5 clk = ~clk;

  logic [DW-1:0] model [DEPTH];
  logic exp_err = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic bit in_win(int n, int lo, int hi);
    return n >= lo && n <= hi;
  endfunction

  function automatic logic [DW-1:0] id_byte(logic a0);
    return a0 ? 8'h02 : 8'hDA;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1; oe_n = 1; vpp_lvl = 2'b00; a9_hv = 0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); ce_n = 0;
    repeat (n) @(negedge clk);
    ce_n = 1;
    @(negedge clk);
  endtask

  task automatic do_prog(logic [AW-1:0] a, logic [DW-1:0] d, int n);
    @(negedge clk);
    vpp_lvl = 2'b01; oe_n = 1; a9_hv = 0; addr = a; din = d;
    pulse(n);
    if (in_win(n, PMIN, PMAX)) model[a] = model[a] & d;
    else exp_err = 1;
    check("R8 err after program", {7'd0, pulse_err}, {7'd0, exp_err});
  endtask

  task automatic rd(string req, logic [AW-1:0] a);
    @(negedge clk);
    vpp_lvl = 2'b00; a9_hv = 0; addr = a; ce_n = 0; oe_n = 0;
    #1;
    check(req, {dout_en, dout[DW-1:1]}, {1'b1, model[a][DW-1:1]});
    check(req, {7'd0, dout[0]}, {7'd0, model[a][0]});
    ce_n = 1; oe_n = 1;
  endtask

  task automatic vfy(logic [AW-1:0] a, logic [1:0] lvl);
    @(negedge clk);
    vpp_lvl = lvl; ce_n = 1; oe_n = 0; addr = a;
    #1;
    check("R6 verify en", {7'd0, dout_en}, 8'd1);
    check("R6 verify data", dout, model[a]);
    oe_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 err", {7'd0, pulse_err}, 8'd0);
    rd("R1 read FF", 0);
    rd("R1 read FF", AW'(DEPTH - 1));
    rd("R1 read FF", 10'd333);

    // R3 output disable and standby
    @(negedge clk); addr = 10'd7; ce_n = 0; oe_n = 1; #1;
    check("R3 oe high", {dout_en, 7'd0}, 8'd0); check("R3 oe high data", dout, 8'd0);
    @(negedge clk); ce_n = 1; oe_n = 0; vpp_lvl = 2'b00; #1;
    check("R3 standby", {7'd0, dout_en}, 8'd0);
    idle();

    // R4 directed: window edges and AND behaviour
    do_prog(10'd5, 8'hA5, PMIN);
    rd("R4 prog at min", 10'd5);
    do_prog(10'd6, 8'h3C, PMAX);
    rd("R4 prog at max", 10'd6);
    do_prog(10'd5, 8'hF0, PMIN + 3);
    rd("R4 AND of repeat", 10'd5);
    check("R4 AND value", model[5], 8'hA0);
    vfy(10'd5, 2'b01);
    vfy(10'd6, 2'b10);

    // R9 pulses with no valid mode
    @(negedge clk); vpp_lvl = 2'b00; oe_n = 1; addr = 10'd5; din = 8'h00;
    pulse(PMIN + 2);
    rd("R9 read-level pulse", 10'd5);
    @(negedge clk); vpp_lvl = 2'b01; oe_n = 0; addr = 10'd6; din = 8'h00;
    pulse(PMIN + 2);
    idle();
    rd("R9 oe low pulse", 10'd6);
    @(negedge clk); vpp_lvl = 2'b10; oe_n = 1; a9_hv = 1; addr = 10'd1;
    pulse(EMIN + 10);
    idle();
    rd("R9 erase nonzero addr", 10'd5);
    check("R9 err untouched", {7'd0, pulse_err}, 8'd0);

    // R7 identifiers
    for (int b = 0; b < 2; b++) begin
      @(negedge clk); vpp_lvl = 2'b00; a9_hv = 1; addr = AW'(b); ce_n = 0; oe_n = 0; #1;
      check("R7 identifier", dout, id_byte(b[0]));
    end
    idle();

    // R4 R6 R8 random programs
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int w;
      a = AW'($urandom % DEPTH);
      d = DW'($urandom);
      case ($urandom % 6)
        0: w = PMIN;
        1: w = PMAX;
        2: w = PMIN - 1;
        3: w = PMAX + 1;
        default: w = PMIN + int'($urandom % (PMAX - PMIN + 1));
      endcase
      do_prog(a, d, w);
      vfy(a, 2'b01);
      rd("R2 read after program", a);
      rd("R2 read neighbour", a ^ 10'd1);
    end

    // R8 directed short program on a cleared bit path
    do_prog(10'd6, 8'h00, PMIN - 1);
    rd("R8 array unchanged", 10'd6);

    // R8 erase with bad width
    @(negedge clk); vpp_lvl = 2'b10; oe_n = 1; a9_hv = 1; addr = '0;
    pulse(EMAX + 1);
    exp_err = 1;
    idle();
    rd("R8 erase too long", 10'd5);
    check("R8 err set", {7'd0, pulse_err}, 8'd1);

    // R5 good erase
    @(negedge clk); vpp_lvl = 2'b10; oe_n = 1; a9_hv = 1; addr = '0;
    pulse(EMIN);
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    idle();
    for (int i = 0; i < DEPTH; i += 37) rd("R5 erased", AW'(i));
    rd("R5 erased", 10'd5);
    rd("R5 erased", 10'd6);
    check("R8 err still set", {7'd0, pulse_err}, 8'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule